// File: doc/BRIEF.md
# Misaligned Access Splitter

This block sits between a load/store pipeline and a data cache port that is eight bytes wide. It accepts one memory request at a time. Each request carries a byte address, an operand size of 1, 2, 4 or 8 bytes, a load/store flag, right-justified store data and an operation class. The block turns the request into one or two cache accesses. Each access goes to a doubleword-aligned address and carries a byte-enable mask. An operand that fits inside one doubleword costs a single access. An operand that straddles a doubleword boundary costs two accesses, lower address first.

For loads, the block keeps the bytes of the first access and combines them with those of the second. It returns a right-justified result with a single completion pulse. For stores, it rotates the operand into the correct byte lanes of each access. The cache reports a fault with each response. A fault on either half ends the request with no partial completion, and the requester replays the request from its first half. The block also reports whether the two halves lie in different 4 KB pages. Block-transfer (load/store multiple) requests that are not word-aligned are refused outright. String-class requests are issued exactly as presented.

Both the request side and the cache command side use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so the requester must hold its request until it is taken. A cache command is transferred on a cycle where `cache_valid` and `cache_ready` are both high. While `cache_ready` is low, the block holds the command unchanged. Responses arrive on `rsp_valid` with no back-pressure, exactly one per transferred command.

Top module: `lsu_split_access`

## Requirements
- R1: If `req_addr[2:0]` plus the operand size is at most 8, exactly one cache access is issued. Its address is `req_addr` with the low three bits cleared, and `cache_be` bit j is set exactly for lanes `req_addr[2:0]` through `req_addr[2:0]`+size-1. The size code is `req_size`: 0=1, 1=2, 2=4, 3=8 bytes. With `cache_ready` high, the command appears the cycle after acceptance, and `done` pulses the cycle after the response.
- R2: If the operand crosses a doubleword boundary, two accesses are issued. The first covers lanes `req_addr[2:0]`..7 of the lower doubleword. The second covers lanes 0..(remainder-1) at the lower doubleword address plus 8. It is issued only after the first response arrives without a fault.
- R3: For a completed load, byte k of `rdata` (bits 8k+7:8k) equals the memory byte at `req_addr`+k for k below the size, and bytes at or above the size are zero. `rdata` is valid in the `done` cycle.
- R4: For a store, byte k of `req_wdata` is the byte for address `req_addr`+k. `cache_wdata` lane j of an access at doubleword address D carries operand byte (D+j-`req_addr`) in every lane that has its enable bit set. `cache_store` follows the request flag.
- R5: A fault on the first access ends the request with a one-cycle `fault` pulse and `fault_second` low. No second access is issued.
- R6: A fault on the second access abandons the whole request with a `fault` pulse and `fault_second` high, and no `done` follows. When the same request is presented again, it restarts with the first doubleword.
- R7: `page_cross`, which is valid with `done` or `fault`, is high exactly when the two accesses of a split request differ in any address bit above bit 11.
- R8: A request of class 2 (block transfer) whose `req_addr[1:0]` is nonzero gets an `align_err` pulse in the cycle after acceptance, and no cache access is issued. A word-aligned class-2 request is handled like class 0 (normal), including splitting.
- R9: A class-1 (string) request is issued as its own access or accesses. Two consecutive string requests to the same doubleword produce two separate accesses. Class 3 behaves as class 0.
- R10: `req_ready` is high only when no request is in progress. At most one cache command is outstanding. While `cache_valid` is high and `cache_ready` is low, the command and its address, enables and data stay unchanged.
- R11: After reset, `req_ready` is high and `cache_valid`, `done`, `fault` and `align_err` are low. `done`, `fault` and `align_err` are one-cycle pulses, and no two of them are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store operand, right-justified |
| req_class | input | 2 | 0 normal, 1 string, 2 block transfer, 3 normal |
| cache_valid | output | 1 | Cache command present |
| cache_ready | input | 1 | Cache takes the command |
| cache_addr | output | 32 | Doubleword-aligned access address |
| cache_store | output | 1 | Access is a write |
| cache_be | output | 8 | Byte-lane enables |
| cache_wdata | output | 64 | Write data in lane position |
| rsp_valid | input | 1 | Response for the outstanding command |
| rsp_rdata | input | 64 | Read data, lane j = byte at address+j |
| rsp_fault | input | 1 | The access faulted |
| done | output | 1 | Request completed (pulse) |
| rdata | output | 64 | Right-justified load result |
| fault | output | 1 | Request abandoned on a fault (pulse) |
| fault_second | output | 1 | Fault came from the second access |
| page_cross | output | 1 | Split request spans two 4 KB pages |
| align_err | output | 1 | Misaligned block-transfer request refused (pulse) |

## Verification
The assertions assume a well-behaved cache. It returns exactly one response for each transferred command, never before the transfer, and raises `rsp_valid` only while the block waits for that response. They also assume the requester holds the request fields steady while `req_valid` is high. The stimulus keeps to these rules because the bench's cache model answers exactly once, one cycle after each transfer. The model inserts a configurable number of stall cycles before raising `cache_ready`. It lowers `req_valid` as soon as a request is taken.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int OFF_W  = $clog2(LANES);
  localparam int LSH    = $clog2(LANE_W);
  localparam int SIZE_W = 2;

  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_STRING = 2'd1,
    CLS_MULTI  = 2'd2,
    CLS_SPARE  = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_LO,
    ST_WAIT_LO,
    ST_ISSUE_HI,
    ST_WAIT_HI
  } split_state_e;

  // Contiguous run of enabled lanes, starting at lane 0, for a size code.
  function automatic logic [2*LANES-1:0] lane_mask(input logic [SIZE_W-1:0] sz);
    logic [2*LANES-1:0] one;
    one    = '0;
    one[0] = 1'b1;
    return (one << (1 << sz)) - one;
  endfunction

  // Block-transfer requests must sit on a 4-byte boundary.
  function automatic logic multi_misaligned(input logic [1:0] a_lo,
                                            input logic [1:0] cls);
    return (cls == CLS_MULTI) && (a_lo != 2'b00);
  endfunction
endpackage

// File: rtl/lss_span_plan.sv
module lss_span_plan
  import lss_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] base_lo,
  output logic [ADDR_W-1:0] base_hi,
  output logic [LANES-1:0]  be_lo,
  output logic [LANES-1:0]  be_hi,
  output logic              crosses,
  output logic              page_cross
);
  logic [2*LANES-1:0] span;

  assign off     = addr[OFF_W-1:0];
  assign base_lo = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign base_hi = base_lo + ADDR_W'(LANES);

  // The operand's lanes laid over two consecutive doublewords.
  assign span    = lane_mask(size) << off;
  assign be_lo   = span[LANES-1:0];
  assign be_hi   = span[2*LANES-1:LANES];
  assign crosses = |be_hi;

  assign page_cross = crosses &&
                      (base_lo[ADDR_W-1:PAGE_W] != base_hi[ADDR_W-1:PAGE_W]);
endmodule

// File: rtl/lss_store_lanes.sv
module lss_store_lanes
  import lss_pkg::*;
(
  input  logic [WORD_W-1:0] wdata,
  input  logic [OFF_W-1:0]  off,
  output logic [WORD_W-1:0] wd_lo,
  output logic [WORD_W-1:0] wd_hi
);
  logic [2*WORD_W-1:0] wide;

  // Slide the right-justified operand up by the byte offset. The low
  // doubleword feeds the first access, the spill-over feeds the second.
  assign wide  = {{WORD_W{1'b0}}, wdata} << {off, {LSH{1'b0}}};
  assign wd_lo = wide[WORD_W-1:0];
  assign wd_hi = wide[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/lss_load_merge.sv
module lss_load_merge
  import lss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              sel_hi,
  input  logic [WORD_W-1:0] rsp_data,
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] held;
  logic [WORD_W-1:0] lo_word;
  logic [WORD_W-1:0] hi_word;
  logic [WORD_W-1:0] shifted;
  logic [LANES-1:0]  keep;

  always_ff @(posedge clk) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= rsp_data;
  end

  // A single access uses the live response as the low word. A split
  // uses the held first half plus the live second half.
  assign lo_word = sel_hi ? held : rsp_data;
  assign hi_word = sel_hi ? rsp_data : '0;
  assign shifted = WORD_W'({hi_word, lo_word} >> {off, {LSH{1'b0}}});
  assign keep    = LANES'(lane_mask(size));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign result[k*LANE_W +: LANE_W] = keep[k] ? shifted[k*LANE_W +: LANE_W]
                                                : '0;
  end
endmodule

// File: rtl/lss_split_ctrl.sv
module lss_split_ctrl
  import lss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic reject,
  input  logic crosses,
  input  logic cache_ready,
  input  logic rsp_valid,
  input  logic rsp_fault,
  output logic idle,
  output logic accept,
  output logic cmd_valid,
  output logic use_hi,
  output logic capture_lo,
  output logic sel_hi,
  output logic finish_ok,
  output logic finish_any,
  output logic done_o,
  output logic fault_o,
  output logic fault_hi_o,
  output logic align_err_o
);
  split_state_e state, state_n;
  logic done_n, fault_n, fault_hi_n, err_n;

  always_comb begin
    state_n    = state;
    done_n     = 1'b0;
    fault_n    = 1'b0;
    err_n      = 1'b0;
    fault_hi_n = fault_hi_o;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          if (reject) err_n   = 1'b1;
          else        state_n = ST_ISSUE_LO;
        end
      end
      ST_ISSUE_LO: if (cache_ready) state_n = ST_WAIT_LO;
      ST_WAIT_LO: begin
        if (rsp_valid) begin
          if (rsp_fault) begin
            fault_n    = 1'b1;
            fault_hi_n = 1'b0;
            state_n    = ST_IDLE;
          end else if (crosses) begin
            state_n = ST_ISSUE_HI;
          end else begin
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end
        end
      end
      ST_ISSUE_HI: if (cache_ready) state_n = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (rsp_valid) begin
          state_n = ST_IDLE;
          if (rsp_fault) begin
            fault_n    = 1'b1;
            fault_hi_n = 1'b1;
          end else begin
            done_n = 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      done_o      <= 1'b0;
      fault_o     <= 1'b0;
      fault_hi_o  <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      state       <= state_n;
      done_o      <= done_n;
      fault_o     <= fault_n;
      fault_hi_o  <= fault_hi_n;
      align_err_o <= err_n;
    end
  end

  assign idle       = (state == ST_IDLE);
  assign accept     = idle && req_valid && !reject;
  assign cmd_valid  = (state == ST_ISSUE_LO) || (state == ST_ISSUE_HI);
  assign use_hi     = (state == ST_ISSUE_HI) || (state == ST_WAIT_HI);
  assign capture_lo = (state == ST_WAIT_LO) && rsp_valid;
  assign sel_hi     = (state == ST_WAIT_HI);
  assign finish_ok  = done_n;
  assign finish_any = done_n || fault_n;

  // R1: a clean single access completes on the next cycle
  a_r1_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_LO && rsp_valid && !rsp_fault && !crosses) |=> done_o);

  // R2: a clean first half of a split leads straight to the second command
  a_r2_second_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_LO && rsp_valid && !rsp_fault && crosses)
      |=> (cmd_valid && use_hi && !done_o));

  // R5: a fault on the first half stops the request before any second access
  a_r5_first_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_LO && rsp_valid && rsp_fault)
      |=> (fault_o && !fault_hi_o && !cmd_valid && idle));

  // R6: a fault on the second half abandons the whole request
  a_r6_second_fault_abandons: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_HI && rsp_valid && rsp_fault)
      |=> (fault_o && fault_hi_o && !done_o && idle));

  // R10: a stalled command stays presented
  a_r10_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cache_ready) |=> cmd_valid);

  // R11: terminal pulses are exclusive and last one cycle
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done_o, fault_o, align_err_o}) <= 1);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/lsu_split_access.sv
module lsu_split_access
  import lss_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_store,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [1:0]        req_class,
  output logic              cache_valid,
  input  logic              cache_ready,
  output logic [ADDR_W-1:0] cache_addr,
  output logic              cache_store,
  output logic [LANES-1:0]  cache_be,
  output logic [WORD_W-1:0] cache_wdata,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_rdata,
  input  logic              rsp_fault,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              fault,
  output logic              fault_second,
  output logic              page_cross,
  output logic              align_err
);
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic              store_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata_q;
  logic              page_q;

  logic              reject, accept, use_hi, capture_lo, sel_hi;
  logic              finish_ok, finish_any;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] base_lo, base_hi;
  logic [LANES-1:0]  be_lo, be_hi;
  logic              crosses, span_page;
  logic [WORD_W-1:0] wd_lo, wd_hi, merged;

  assign reject = multi_misaligned(req_addr[1:0], req_class);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= '0;
      store_q <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      size_q  <= req_size;
      store_q <= req_store;
      wdata_q <= req_wdata;
    end
  end

  lss_span_plan #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_plan (
    .addr       (addr_q),
    .size       (size_q),
    .off        (off),
    .base_lo    (base_lo),
    .base_hi    (base_hi),
    .be_lo      (be_lo),
    .be_hi      (be_hi),
    .crosses    (crosses),
    .page_cross (span_page)
  );

  lss_store_lanes u_store (
    .wdata (wdata_q),
    .off   (off),
    .wd_lo (wd_lo),
    .wd_hi (wd_hi)
  );

  lss_load_merge u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture_lo),
    .sel_hi   (sel_hi),
    .rsp_data (rsp_rdata),
    .off      (off),
    .size     (size_q),
    .result   (merged)
  );

  lss_split_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .reject      (reject),
    .crosses     (crosses),
    .cache_ready (cache_ready),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .idle        (req_ready),
    .accept      (accept),
    .cmd_valid   (cache_valid),
    .use_hi      (use_hi),
    .capture_lo  (capture_lo),
    .sel_hi      (sel_hi),
    .finish_ok   (finish_ok),
    .finish_any  (finish_any),
    .done_o      (done),
    .fault_o     (fault),
    .fault_hi_o  (fault_second),
    .align_err_o (align_err)
  );

  assign cache_addr  = use_hi ? base_hi : base_lo;
  assign cache_be    = use_hi ? be_hi   : be_lo;
  assign cache_wdata = use_hi ? wd_hi   : wd_lo;
  assign cache_store = store_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      page_q  <= 1'b0;
    end else begin
      if (finish_ok)  rdata_q <= store_q ? '0 : merged;
      if (finish_any) page_q  <= span_page;
    end
  end

  assign rdata      = rdata_q;
  assign page_cross = page_q;

  // R10: address, enables and data are frozen while the cache stalls
  a_r10_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && !cache_ready)
      |=> ($stable(cache_addr) && $stable(cache_be) && $stable(cache_wdata)));

  // R10: no command while the request side is open
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cache_valid);

  // R8: a refused request never reaches the cache
  a_r8_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!cache_valid && req_ready));

  // R2: the first half of a split ends at the top lane, the second starts at lane 0
  a_r2_split_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && crosses)
      |-> (use_hi ? cache_be[0] : cache_be[LANES-1]));

  // R1: every command enables at least one lane
  a_r1_lanes_present: assert property (@(posedge clk) disable iff (!rst_n)
    cache_valid |-> (cache_be != '0));
endmodule

// File: tb/tb_lsu_split_access.sv
module tb_lsu_split_access;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_store;
  logic [31:0] req_addr;
  logic [1:0]  req_size, req_class;
  logic [63:0] req_wdata;
  logic        cache_valid, cache_ready, cache_store;
  logic [31:0] cache_addr;
  logic [7:0]  cache_be;
  logic [63:0] cache_wdata;
  logic        rsp_valid, rsp_fault;
  logic [63:0] rsp_rdata;
  logic        done, fault, fault_second, page_cross, align_err;
  logic [63:0] rdata;

  always #2 clk = ~clk;

  lsu_split_access dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_store(req_store), .req_wdata(req_wdata),
    .req_class(req_class),
    .cache_valid(cache_valid), .cache_ready(cache_ready), .cache_addr(cache_addr),
    .cache_store(cache_store), .cache_be(cache_be), .cache_wdata(cache_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .done(done), .rdata(rdata), .fault(fault), .fault_second(fault_second),
    .page_cross(page_cross), .align_err(align_err)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  bit          fin   = 1'b0;
  logic [31:0] fault_dw = 32'hFFFF_FFFF;
  logic [31:0] q_base[$];
  logic [7:0]  q_be[$];
  logic [63:0] q_wd[$];

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37;
    return t ^ a[15:8] ^ 8'hC3;
  endfunction

  function automatic logic [63:0] mem_dw(input logic [31:0] d);
    logic [63:0] r;
    for (int j = 0; j < 8; j++) r[j*8 +: 8] = mem_byte(d + 32'(j));
    return r;
  endfunction

  // Expected access: lanes whose address falls inside the operand.
  task automatic push_access(input logic [31:0] base, input logic [31:0] a,
                             input int nb, input logic [63:0] wd);
    logic [7:0]  be;
    logic [63:0] w;
    be = '0;
    w  = '0;
    for (int j = 0; j < 8; j++) begin
      logic [31:0] la;
      la = base + 32'(j);
      if (la >= a && la < a + 32'(nb)) begin
        be[j] = 1'b1;
        w[j*8 +: 8] = wd[(la - a)*8 +: 8];
      end
    end
    q_base.push_back(base);
    q_be.push_back(be);
    q_wd.push_back(w);
  endtask

  task automatic run_req(input logic [31:0] a, input logic [1:0] sz,
                         input bit st, input logic [63:0] wd,
                         input logic [1:0] cls, input int stall,
                         input string tag);
    int          nb, off, it, stall_left, exp_it, n_exp;
    bit          split, err, f0, f1, pend, seen, term;
    logic [31:0] d0, d1, pend_base, hold_addr;
    logic [63:0] exp_rd;
    nb    = 1 << sz;
    off   = int'(a[2:0]);
    d0    = {a[31:3], 3'b000};
    d1    = d0 + 32'd8;
    split = (off + nb) > 8;
    err   = (cls == 2'd2) && (a[1:0] != 2'b00);
    f0    = (d0 == fault_dw);
    f1    = split && !f0 && (d1 == fault_dw);
    q_base.delete(); q_be.delete(); q_wd.delete();
    if (!err) begin
      push_access(d0, a, nb, wd);
      if (split && !f0) push_access(d1, a, nb, wd);
    end
    n_exp  = q_base.size();
    exp_it = err ? 1 : n_exp * (2 + stall) + 1;
    exp_rd = '0;
    for (int k = 0; k < nb; k++) exp_rd[k*8 +: 8] = mem_byte(a + 32'(k));

    @(negedge clk);
    chk(req_ready === 1'b1, {"R10 ready before request ", tag}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_store = st;
    req_wdata = wd; req_class = cls;
    pend = 0; seen = 0; term = 0; it = 0; stall_left = stall;
    pend_base = '0; hold_addr = '0;
    while (!term && it < 60) begin
      @(negedge clk);
      it++;
      req_valid = 1'b0; rsp_valid = 1'b0; rsp_fault = 1'b0;
      if (done || fault || align_err) begin
        term = 1;
      end else begin
        chk(req_ready === 1'b0, {"R10 busy blocks requests ", tag}, 64'(req_ready), 64'd0);
        if (pend) begin
          rsp_valid = 1'b1;
          rsp_rdata = mem_dw(pend_base);
          rsp_fault = (pend_base == fault_dw);
          pend = 0;
          cache_ready = 1'b0;
        end else if (cache_valid) begin
          if (!seen) begin
            seen = 1; hold_addr = cache_addr;
          end else begin
            chk(cache_addr == hold_addr, {"R10 stalled address held ", tag}, 64'(cache_addr), 64'(hold_addr));
          end
          if (stall_left > 0) begin
            stall_left--;
            cache_ready = 1'b0;
          end else begin
            cache_ready = 1'b1;
            if (q_base.size() == 0) begin
              chk(1'b0, {"R1 unexpected extra access ", tag}, 64'(cache_addr), 64'd0);
            end else begin
              logic [31:0] eb; logic [7:0] ebe; logic [63:0] ew;
              eb = q_base.pop_front(); ebe = q_be.pop_front(); ew = q_wd.pop_front();
              chk(cache_addr == eb, {"R2 access address ", tag}, 64'(cache_addr), 64'(eb));
              chk(cache_be == ebe, {"R1 byte enables ", tag}, 64'(cache_be), 64'(ebe));
              chk(cache_store == st, {"R4 access direction ", tag}, 64'(cache_store), 64'(st));
              if (st) begin
                logic [63:0] m;
                for (int j = 0; j < 8; j++) m[j*8 +: 8] = {8{ebe[j]}};
                chk((cache_wdata & m) == ew, {"R4 store lanes ", tag}, cache_wdata & m, ew);
              end
            end
            pend = 1; pend_base = cache_addr; seen = 0; stall_left = stall;
          end
        end else begin
          cache_ready = 1'b0;
        end
      end
    end
    cache_ready = 1'b0;

    chk(it == exp_it, {split ? "R2 completion cycle " : "R1 completion cycle ", tag}, 64'(it), 64'(exp_it));
    chk(q_base.size() == 0, {"R2 all accesses issued ", tag}, 64'(q_base.size()), 64'd0);
    chk($countones({done, fault, align_err}) <= 1, {"R11 exclusive pulses ", tag},
        64'({done, fault, align_err}), 64'd0);
    if (err) begin
      chk(align_err && !done && !fault, {"R8 refused ", tag}, 64'({align_err, done, fault}), 64'b100);
    end else if (f0 || f1) begin
      chk(fault && !done, {f1 ? "R6 fault ends request " : "R5 fault ends request ", tag},
          64'({fault, done}), 64'b10);
      chk(fault_second == f1, {f1 ? "R6 fault half " : "R5 fault half ", tag},
          64'(fault_second), 64'(f1));
    end else begin
      chk(done && !fault, {"R11 done pulse ", tag}, 64'({done, fault}), 64'b10);
      if (!st) chk(rdata == exp_rd, {"R3 load result ", tag}, rdata, exp_rd);
    end
    if (!err) begin
      logic ep;
      ep = split && (d0[31:12] != d1[31:12]);
      chk(page_cross == ep, {"R7 page flag ", tag}, 64'(page_cross), 64'(ep));
    end
    @(negedge clk);
    chk(!done && !fault && !align_err && req_ready, {"R11 one-cycle pulse ", tag},
        64'({done, fault, align_err, req_ready}), 64'b0001);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_store = 1'b0; req_wdata = '0; req_class = '0;
    cache_ready = 1'b0; rsp_valid = 1'b0; rsp_rdata = '0; rsp_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cache_valid && !done && !fault && !align_err, "R11 reset state",
        64'({req_ready, cache_valid, done, fault, align_err}), 64'b10000);

    run_req(32'h0000_0100, 2'd3, 0, '0, 2'd0, 0, "R1 aligned dword load");
    run_req(32'h0000_0103, 2'd1, 0, '0, 2'd0, 0, "R1 inner halfword load");
    run_req(32'h0000_0106, 2'd2, 0, '0, 2'd0, 0, "R2 R3 word split load");
    run_req(32'h0000_010D, 2'd3, 0, '0, 2'd0, 0, "R2 R3 dword split load");
    run_req(32'h0000_0205, 2'd3, 1, 64'h1122_3344_5566_7788, 2'd0, 0, "R4 split store");
    run_req(32'h0000_031E, 2'd1, 1, 64'h0000_0000_0000_A5C3, 2'd0, 0, "R4 halfword store");
    run_req(32'h0000_0327, 2'd1, 1, 64'h0000_0000_0000_BEEF, 2'd3, 0, "R4 R9 class3 split store");
    run_req(32'h0000_0412, 2'd3, 0, '0, 2'd0, 2, "R10 stalled split load");
    run_req(32'h0000_0FFE, 2'd2, 0, '0, 2'd0, 1, "R7 page crossing load");
    run_req(32'h0000_1FFA, 2'd3, 1, 64'hCAFE_F00D_DEAD_BEEF, 2'd0, 0, "R7 R4 page crossing store");

    fault_dw = 32'h0000_2000;
    run_req(32'h0000_1FFC, 2'd3, 0, '0, 2'd0, 0, "R6 second half faults");
    fault_dw = 32'hFFFF_FFFF;
    run_req(32'h0000_1FFC, 2'd3, 0, '0, 2'd0, 0, "R6 replay from first half");

    fault_dw = 32'h0000_0400;
    run_req(32'h0000_0400, 2'd1, 0, '0, 2'd0, 0, "R5 single access faults");
    fault_dw = 32'h0000_04F8;
    run_req(32'h0000_04FE, 2'd2, 0, '0, 2'd0, 0, "R5 first half of split faults");
    fault_dw = 32'hFFFF_FFFF;

    run_req(32'h0000_0502, 2'd2, 0, '0, 2'd2, 0, "R8 misaligned block load");
    run_req(32'h0000_0511, 2'd2, 1, 64'h1234_5678, 2'd2, 0, "R8 misaligned block store");
    run_req(32'h0000_0504, 2'd3, 0, '0, 2'd2, 0, "R8 aligned block split load");

    run_req(32'h0000_0600, 2'd0, 0, '0, 2'd1, 0, "R9 string byte 0");
    run_req(32'h0000_0601, 2'd0, 0, '0, 2'd1, 0, "R9 string byte 1 same dword");
    run_req(32'h0000_0607, 2'd1, 0, '0, 2'd1, 0, "R9 string split");

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule